// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Loader

This block is the digital front end of a two-channel 12-bit converter. A host with an 8-bit bus writes each channel's code in two parts. The low byte and the high nibble go into separate staging registers, and a two-bit address picks the register. Staging registers do not reach the converter until a shared update strobe copies both channels' staged codes into their output registers on the same clock edge, so the two channels always change together.

All strobes are active low. A write happens on a rising clock edge where the write strobe is low and chip select or update is also low. An asynchronous active-low clear empties all six registers at once. When chip select, update and write are all low together, the block is transparent. The staging register being written takes the bus byte, and both output registers take the updated staged values on that same edge. The two 12-bit output codes are ports that feed the analog stage.

Top module: `dual_dac_loader`

## Requirements
- R1: While `clrN` is low, all six registers are zero and both output codes read 0, whatever the other inputs do. The clear acts without waiting for a clock edge.
- R2: A staging register changes only on a clock edge where `csN` and `wrN` are both low.
- R3: `addr` selects the staging register: 0 is channel A low, 1 is channel A high, 2 is channel B low and 3 is channel B high. Only the selected register changes.
- R4: A low-register write stores `dataBus[7:0]` as code bits 7..0. A high-register write stores `dataBus[3:0]` as code bits 11..8. On a high write, `dataBus[7:4]` has no effect.
- R5: On an edge with `updN` and `wrN` low and `csN` high, both output registers take their channel's staged code, `{high, low}`. No staging register changes.
- R6: On an edge with `csN`, `wrN` and `updN` all low, the selected staging register loads. On that same edge, both output codes take the staged values that include this write.
- R7: On any edge where `wrN` is high or `updN` is high, neither output code changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; writes take effect on its rising edge |
| clrN | input | 1 | Asynchronous clear, active low |
| csN | input | 1 | Chip select, active low, enables staging writes |
| wrN | input | 1 | Write strobe, active low |
| updN | input | 1 | Update strobe, active low, copies staged codes to outputs |
| addr | input | 2 | Staging register select |
| dataBus | input | 8 | Host data bus |
| codeA | output | 12 | Channel A output code |
| codeB | output | 12 | Channel B output code |

## Verification
The assertions assume that the strobes, address and bus are steady around the rising clock edge. They also assume that `clrN` changes only between edges, so that an edge never sees a clear that is just being released. The stimulus drives every input on the falling edge and holds it for a whole cycle. Clear is asserted and released only on falling edges, and one directed case asserts it between edges to show that it acts without a clock. Random cycles mix every strobe combination and every address with random bytes, including high-nibble writes with the upper bus bits set.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
  localparam int NUM_CH = 2;
  localparam int NUM_REGS = 2 * NUM_CH;

  typedef struct packed {
    logic [NUM_REGS-1:0] ldEn;   // one-hot staging load, index = addr
    logic                xferEn; // copy staged codes to outputs
  } strobe_t;
endpackage

// File: rtl/dac_loader_ctrl.sv
module dac_loader_ctrl
  import dac_loader_pkg::*;
(
  input  logic       csN,
  input  logic       wrN,
  input  logic       updN,
  input  logic [1:0] addr,
  output strobe_t    strb
);
  logic stageWr;

  assign stageWr = ~csN & ~wrN;

  always_comb begin
    strb.ldEn = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (stageWr && (addr == i[1:0])) strb.ldEn[i] = 1'b1;
    end
    strb.xferEn = ~updN & ~wrN;
  end
endmodule

// File: rtl/dac_loader_path.sv
module dac_loader_path
  import dac_loader_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int HI_W  = 4,
  localparam int CODE_W = BUS_W + HI_W
) (
  input  logic                          clk,
  input  logic                          clrN,
  input  strobe_t                       strb,
  input  logic [BUS_W-1:0]              dataBus,
  output logic [NUM_CH-1:0][BUS_W-1:0]  inLo,
  output logic [NUM_CH-1:0][HI_W-1:0]   inHi,
  output logic [NUM_CH-1:0][CODE_W-1:0] codeOut
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [BUS_W-1:0]  loReg, loNext;
    logic [HI_W-1:0]   hiReg, hiNext;
    logic [CODE_W-1:0] outReg;

    always_comb begin
      loNext = strb.ldEn[2*c]   ? dataBus            : loReg;
      hiNext = strb.ldEn[2*c+1] ? dataBus[HI_W-1:0]  : hiReg;
    end

    always_ff @(posedge clk or negedge clrN) begin
      if (!clrN) begin
        loReg  <= '0;
        hiReg  <= '0;
        outReg <= '0;
      end else begin
        loReg <= loNext;
        hiReg <= hiNext;
        if (strb.xferEn) outReg <= {hiNext, loNext};
      end
    end

    assign inLo[c]    = loReg;
    assign inHi[c]    = hiReg;
    assign codeOut[c] = outReg;
  end
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dac_loader_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int HI_W  = 4,
  localparam int CODE_W = BUS_W + HI_W
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              updN,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  dataBus,
  output logic [CODE_W-1:0] codeA,
  output logic [CODE_W-1:0] codeB
);
  strobe_t                       strb;
  logic [NUM_CH-1:0][BUS_W-1:0]  inLo;
  logic [NUM_CH-1:0][HI_W-1:0]   inHi;
  logic [NUM_CH-1:0][CODE_W-1:0] codeOut;

  dac_loader_ctrl u_ctrl (
    .csN(csN), .wrN(wrN), .updN(updN), .addr(addr), .strb(strb)
  );

  dac_loader_path #(.BUS_W(BUS_W), .HI_W(HI_W)) u_path (
    .clk(clk), .clrN(clrN), .strb(strb), .dataBus(dataBus),
    .inLo(inLo), .inHi(inHi), .codeOut(codeOut)
  );

  assign codeA = codeOut[0];
  assign codeB = codeOut[1];
endmodule

// File: rtl/dual_dac_loader_chk.sv
module dual_dac_loader_chk #(
  parameter int BUS_W = 8,
  parameter int HI_W  = 4,
  localparam int CODE_W = BUS_W + HI_W
) (
  input logic                    clk,
  input logic                    clrN,
  input logic                    csN,
  input logic                    wrN,
  input logic                    updN,
  input logic [CODE_W-1:0]       codeA,
  input logic [CODE_W-1:0]       codeB,
  input logic [1:0][BUS_W-1:0]   inLo,
  input logic [1:0][HI_W-1:0]    inHi
);
  a_r1_clear_zero: assert property (@(posedge clk)
    !clrN |-> (codeA == '0) && (codeB == '0) && (inLo == '0) && (inHi == '0));

  a_r2_stage_gate: assert property (@(posedge clk) disable iff (!clrN)
    (csN || wrN) |=> $stable(inLo) && $stable(inHi));

  a_r5_transfer: assert property (@(posedge clk) disable iff (!clrN)
    (!updN && !wrN && csN) |=>
      (codeA == {$past(inHi[0]), $past(inLo[0])}) &&
      (codeB == {$past(inHi[1]), $past(inLo[1])}) &&
      $stable(inLo) && $stable(inHi));

  a_r6_transparent: assert property (@(posedge clk) disable iff (!clrN)
    (!updN && !wrN && !csN) |=>
      (codeA == {inHi[0], inLo[0]}) && (codeB == {inHi[1], inLo[1]}));

  a_r7_hold: assert property (@(posedge clk) disable iff (!clrN)
    (wrN || updN) |=> $stable(codeA) && $stable(codeB));
endmodule

bind dual_dac_loader dual_dac_loader_chk #(.BUS_W(BUS_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .clrN(clrN), .csN(csN), .wrN(wrN), .updN(updN),
  .codeA(codeA), .codeB(codeB), .inLo(inLo), .inHi(inHi)
);

// File: tb/dual_dac_loader_bench.sv
module dual_dac_loader_bench;
  logic        clk = 1'b0;
  logic        clrN = 1'b1;
  logic        csN = 1'b1, wrN = 1'b1, updN = 1'b1;
  logic [1:0]  addr = '0;
  logic [7:0]  dataBus = '0;
  logic [11:0] codeA, codeB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  mLo [2];
  logic [3:0]  mHi [2];
  logic [11:0] mOut[2];

  always #5 clk = ~clk;

  dual_dac_loader u_dual_dac_loader (
    .clk(clk), .clrN(clrN), .csN(csN), .wrN(wrN), .updN(updN),
    .addr(addr), .dataBus(dataBus), .codeA(codeA), .codeB(codeB)
  );

  function automatic logic [11:0] joinCode(logic [3:0] hi, logic [7:0] lo);
    return {hi, lo};
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int c = 0; c < 2; c++) begin
      mLo[c] = '0; mHi[c] = '0; mOut[c] = '0;
    end
  endtask

  // model of one clock edge (R2..R7)
  task automatic modelEdge(logic cs, logic wr, logic upd, logic [1:0] a, logic [7:0] d);
    if (!cs && !wr) begin
      if (a[0]) mHi[a[1]] = d[3:0];
      else      mLo[a[1]] = d;
    end
    if (!upd && !wr)
      for (int c = 0; c < 2; c++) mOut[c] = joinCode(mHi[c], mLo[c]);
  endtask

  // called right after a falling edge; returns at the next falling edge
  task automatic cycle(string tag, logic cs, logic wr, logic upd, logic [1:0] a, logic [7:0] d);
    csN = cs; wrN = wr; updN = upd; addr = a; dataBus = d;
    @(posedge clk);
    if (clrN) modelEdge(cs, wr, upd, a, d);
    @(negedge clk);
    check({tag, " chA"}, codeA, mOut[0]);
    check({tag, " chB"}, codeB, mOut[1]);
  endtask

  initial begin
    void'($urandom(32'h1234abcd));
    modelClear();
    #2 clrN = 1'b0;
    @(negedge clk);
    check("R1 reset chA", codeA, 12'h000);
    check("R1 reset chB", codeB, 12'h000);
    cycle("R1 clear blocks write", 1'b0, 1'b0, 1'b0, 2'd0, 8'hFF);
    clrN = 1'b1;

    // R3/R4 address map and justification, then R5 transfer
    cycle("R3 load A lo", 1'b0, 1'b0, 1'b1, 2'd0, 8'h5A);
    cycle("R4 load A hi upper ignored", 1'b0, 1'b0, 1'b1, 2'd1, 8'hF3);
    cycle("R3 load B lo", 1'b0, 1'b0, 1'b1, 2'd2, 8'hC7);
    cycle("R4 load B hi", 1'b0, 1'b0, 1'b1, 2'd3, 8'hA9);
    cycle("R7 outputs held before update", 1'b1, 1'b1, 1'b0, 2'd0, 8'h00);
    cycle("R5 simultaneous update", 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    check("R4 chA value", codeA, 12'h35A);
    check("R3 chB value", codeB, 12'h9C7);

    // R2: chip select high blocks staging; visible after next update
    cycle("R2 cs high no load", 1'b1, 1'b0, 1'b1, 2'd0, 8'h11);
    cycle("R5 update after blocked write", 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    check("R2 chA unchanged", codeA, 12'h35A);

    // R6 transparent
    cycle("R6 transparent B hi", 1'b0, 1'b0, 1'b0, 2'd3, 8'h0E);
    check("R6 chB flows", codeB, 12'hEC7);

    // R1 asynchronous clear between edges
    #1 clrN = 1'b0;
    #1;
    check("R1 async chA", codeA, 12'h000);
    check("R1 async chB", codeB, 12'h000);
    modelClear();
    @(negedge clk);
    clrN = 1'b1;
    cycle("R1 staging cleared", 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic cs, wr, upd;
      cs  = ($urandom % 3) == 0;
      wr  = ($urandom % 4) == 0;
      upd = ($urandom % 3) != 0;
      cycle("R7 random", cs, wr, upd, 2'($urandom), 8'($urandom));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule